// File: doc/BRIEF.md
# Bit-Serial Shift-Register Adder

This block adds two unsigned operands of `WIDTH` bits using one full adder and one carry flip-flop. It works on one bit position per clock. The operands sit in two right-shifting registers, the augend register and the addend register. Both are filled in parallel while the block is idle.

A one-cycle start pulse launches exactly `WIDTH` shift cycles. In each shift cycle the full adder combines the low bits of both registers with the stored carry. The sum bit enters the augend register at its most significant end, and the carry-out is stored for the next cycle. The addend register takes a zero at its top on each shift.

When the last shift completes, the augend register holds the sum modulo 2^WIDTH and the carry flip-flop holds the final carry. A one-cycle done flag marks this moment. The block suits designs that trade latency for a minimal adder: one full-adder cell serves any operand width.

Top module: `sadd_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done`, `carry_out` and all bits of `sum_out` are 0.
- R2: While idle, a cycle with `load_en` high captures `a_in` into the augend register and `b_in` into the addend register. `sum_out` shows `a_in` from the next cycle. While idle without `load_en`, `sum_out` holds its value.
- R3: `load_en` has no effect while `busy` is high; the result of the running addition is unchanged.
- R4: A `start` pulse while idle raises `busy` from the next cycle, and `busy` then stays high for exactly `WIDTH` cycles.
- R5: `done` is high for exactly one cycle, the first cycle after the last shift, in which `busy` is already low.
- R6: When `done` is high, `sum_out` equals (A + B) mod 2^WIDTH and `carry_out` equals bit `WIDTH` of A + B. For example, 8'h04 + 8'h07 gives 8'h0B with carry 0.
- R7: The carry flip-flop is cleared when an addition starts, so `carry_out` is 0 in the first busy cycle whatever the previous result was.
- R8: `start` has no effect while `busy` is high; the run neither restarts nor lengthens.
- R9: If `load_en` and `start` are both high in the same idle cycle, the load is performed, the start is dropped and `busy` stays low.
- R10: Bits are processed least significant first and both registers shift right. After the first shift, `sum_out[WIDTH-1]` is a[0] XOR b[0] and `sum_out[WIDTH-2:0]` is a[WIDTH-1:1].
- R11: After an addition the addend register holds all zeros. A new start without a load therefore returns the previous sum unchanged with `carry_out` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Parallel load of both operand registers (idle only) |
| a_in | input | WIDTH | Augend load value |
| b_in | input | WIDTH | Addend load value |
| start | input | 1 | One-cycle pulse that begins an addition |
| busy | output | 1 | High during the shift cycles |
| done | output | 1 | One-cycle flag after the last shift |
| sum_out | output | WIDTH | Augend register contents; the sum after `done` |
| carry_out | output | 1 | Carry flip-flop; the final carry after `done` |

## Verification
Two pairs of functions can meet in one cycle.

The first pair is load and start in the same idle cycle. The bench drives both together and then checks three things: the load took effect, `busy` stayed low, and a normal start afterwards gives the expected sum.

The second pair is a shift together with a load or start request during a run. The bench pulses `load_en` and `start` with random values during random additions. It then requires the run to last exactly `WIDTH` cycles and the sum and carry to match a model computed from the original operands.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        SR_HOLD  = 2'd0,
        SR_LOAD  = 2'd1,
        SR_SHIFT = 2'd2
    } sr_op_e;

endpackage

// File: rtl/sadd_fa.sv
module sadd_fa (
    input  logic x,
    input  logic y,
    input  logic cin,
    output logic s,
    output logic cout
);
    always_comb begin
        s    = x ^ y ^ cin;
        cout = (x & y) | (cin & (x ^ y));
    end
endmodule

// File: rtl/sadd_shreg.sv
module sadd_shreg
    import sadd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sr_op_e           op,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q,
    output logic             lsb
);
    logic [WIDTH-1:0] data_d, data_q;

    // each stage picks neighbour (shift), parallel input (load) or itself
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic nbr;
        if (i == WIDTH - 1) begin : g_top
            assign nbr = ser_in;
        end else begin : g_mid
            assign nbr = data_q[i+1];
        end
        always_comb begin
            unique case (op)
                SR_SHIFT: data_d[i] = nbr;
                SR_LOAD:  data_d[i] = par_in[i];
                default:  data_d[i] = data_q[i];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign q   = data_q;
    assign lsb = data_q[0];
endmodule

// File: rtl/sadd_ctrl.sv
module sadd_ctrl
    import sadd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   load_req,
    input  logic   carry_new,
    output sr_op_e op,
    output logic   carry,
    output logic   busy,
    output logic   done
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic          carry;
        logic          done;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        op        = SR_HOLD;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (load_req) begin
                    op = SR_LOAD;            // load wins over start
                end else if (start) begin
                    st_d.phase = PH_RUN;
                    st_d.cnt   = '0;
                    st_d.carry = 1'b0;
                end
            end
            default: begin
                op         = SR_SHIFT;
                st_d.carry = carry_new;
                if (st_q.cnt == LAST) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, cnt: '0, carry: 1'b0, done: 1'b0};
        else        st_q <= st_d;
    end

    assign carry = st_q.carry;
    assign busy  = (st_q.phase == PH_RUN);
    assign done  = st_q.done;
endmodule

// File: rtl/sadd_top.sv
module sadd_top
    import sadd_pkg::*;
#(
    parameter int   WIDTH = 8,
    parameter logic FILL  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);
    sr_op_e           op;
    logic             a_lsb, b_lsb, sum_bit, carry_new, carry_q;
    logic [WIDTH-1:0] b_q;

    sadd_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .load_req(load_en),
        .carry_new(carry_new), .op(op), .carry(carry_q),
        .busy(busy), .done(done)
    );

    sadd_shreg #(.WIDTH(WIDTH)) u_reg_a (
        .clk(clk), .rst_n(rst_n), .op(op), .par_in(a_in),
        .ser_in(sum_bit), .q(sum_out), .lsb(a_lsb)
    );

    sadd_shreg #(.WIDTH(WIDTH)) u_reg_b (
        .clk(clk), .rst_n(rst_n), .op(op), .par_in(b_in),
        .ser_in(FILL), .q(b_q), .lsb(b_lsb)
    );

    sadd_fa u_fa (
        .x(a_lsb), .y(b_lsb), .cin(carry_q), .s(sum_bit), .cout(carry_new)
    );

    assign carry_out = carry_q;
endmodule

// File: rtl/sadd_check.sv
module sadd_check #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_en,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] sum_out,
    input logic             carry_out
);
    logic past_ok;
    int   run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
            run_cnt <= 0;
        end else begin
            past_ok <= 1'b1;
            run_cnt <= busy ? run_cnt + 1 : 0;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        done |=> !done); // R5
    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        done |-> (!busy && $past(busy))); // R5
    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $fell(busy) |-> (run_cnt == WIDTH)); // R4
    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $past(busy) |-> (sum_out[WIDTH-2:0] == $past(sum_out[WIDTH-1:1]))); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (!busy && !load_en) |=> $stable(sum_out)); // R2
    AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (!busy && start && !load_en) |=> (busy && !carry_out)); // R7
    AST_LOAD_BEATS_START: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (!busy && load_en) |=> !busy); // R9
endmodule

bind sadd_top sadd_check #(.WIDTH(WIDTH)) u_sadd_check (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .start(start),
    .busy(busy), .done(done), .sum_out(sum_out), .carry_out(carry_out)
);

// File: tb/test_sadd_top.sv
`timescale 1ns/1ps
module test_sadd_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_en = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         busy, done, carry_out;
    logic [W-1:0] sum_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sadd_top #(.WIDTH(W)) i_sadd_top (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .a_in(a_in), .b_in(b_in),
        .start(start), .busy(busy), .done(done), .sum_out(sum_out),
        .carry_out(carry_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W:0] ref_sum(input logic [W-1:0] a, input logic [W-1:0] b);
        return {1'b0, a} + {1'b0, b};
    endfunction

    task automatic load_ops(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        load_en = 1'b1; a_in = a; b_in = b;
        @(negedge clk);
        load_en = 1'b0;
        chk(sum_out == a, "R2 load", sum_out, a);
    endtask

    // registers must hold a and b on entry
    task automatic add_run(input logic [W-1:0] a, input logic [W-1:0] b, input bit disturb);
        logic [W:0] exp;
        int cyc;
        exp = ref_sum(a, b);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R4 busy after start", busy, 1);
        chk(carry_out == 1'b0, "R7 carry cleared", carry_out, 0);
        cyc = 1;
        for (int k = 0; k < W + 4; k++) begin
            if (disturb) begin
                load_en = 1'($urandom_range(0, 1));
                start   = 1'($urandom_range(0, 1));
                a_in    = W'($urandom);
                b_in    = W'($urandom);
            end
            @(negedge clk);
            load_en = 1'b0;
            start   = 1'b0;
            if (k == 0)
                chk(sum_out == {a[0] ^ b[0], a[W-1:1]}, "R10 first shift",
                    sum_out, {a[0] ^ b[0], a[W-1:1]});
            if (!busy) break;
            cyc++;
        end
        chk(cyc == W, "R4 R8 run length", cyc, W);
        chk(done == 1'b1, "R5 done raised", done, 1);
        chk(sum_out == exp[W-1:0], disturb ? "R3 R6 sum" : "R6 sum", sum_out, exp[W-1:0]);
        chk(carry_out == exp[W], "R6 carry", carry_out, exp[W]);
        @(negedge clk);
        chk(done == 1'b0, "R5 done single cycle", done, 0);
        chk(sum_out == exp[W-1:0], "R2 idle hold", sum_out, exp[W-1:0]);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [W-1:0] ra, rb;
        void'($urandom(32'h5A1D));
        repeat (3) @(negedge clk);
        chk({busy, done, carry_out, sum_out} == '0, "R1 in reset",
            {busy, done, carry_out, sum_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, carry_out, sum_out} == '0, "R1 after reset",
            {busy, done, carry_out, sum_out}, 0);

        // directed corner cases
        load_ops(8'h04, 8'h07); add_run(8'h04, 8'h07, 1'b0);
        load_ops(8'hFF, 8'h01); add_run(8'hFF, 8'h01, 1'b0);
        load_ops(8'hFF, 8'hFF); add_run(8'hFF, 8'hFF, 1'b0);
        load_ops(8'h00, 8'h00); add_run(8'h00, 8'h00, 1'b0);

        // R11: addend zero-filled; restart without load keeps sum, carry 0
        load_ops(8'hF0, 8'h20); add_run(8'hF0, 8'h20, 1'b0);
        add_run(8'h10, 8'h00, 1'b0);
        chk(carry_out == 1'b0, "R11 restart carry", carry_out, 0);
        chk(sum_out == 8'h10, "R11 restart sum", sum_out, 8'h10);

        // R9: load and start in the same idle cycle
        @(negedge clk);
        load_en = 1'b1; start = 1'b1; a_in = 8'h33; b_in = 8'h44;
        @(negedge clk);
        load_en = 1'b0; start = 1'b0;
        chk(busy == 1'b0, "R9 start dropped", busy, 0);
        chk(sum_out == 8'h33, "R9 load taken", sum_out, 8'h33);
        @(negedge clk);
        chk(busy == 1'b0, "R9 still idle", busy, 0);
        add_run(8'h33, 8'h44, 1'b0);

        // random runs, half with load/start noise during the run
        for (int n = 0; n < 40; n++) begin
            ra = W'($urandom);
            rb = W'($urandom);
            if (n % 7 == 0) rb = ~ra;
            load_ops(ra, rb);
            add_run(ra, rb, n[0]);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule